// File: doc/BRIEF.md
# Mixed-Radix Countdown Alarm

This block is a relative alarm timer. Software loads a remaining interval, expressed as days, hours, minutes and seconds. While counting is enabled, the interval decreases by one second on every one-second strobe. When it reaches zero, a pending flag is raised and the count stays at zero. The pending flag reaches the interrupt line only when a separate interrupt-enable bit is set. Software clears the flag by writing one to the status register.

Four registers sit on a simple single-cycle register port:

| Offset | Register |
|--------|----------|
| 0x0C | Interval |
| 0x14 | Counter enable |
| 0x18 | Interrupt enable |
| 0x1C | Status |

All reads are combinational. Each write takes effect at the next clock edge.

To reprogram the alarm, software:

1. Stops the counter.
2. Writes zero to the interval.
3. Writes the new interval.
4. Sets the interrupt enable and the counter enable again.

Top module: `alarm_countdown`

## Requirements
- R1: After reset, the interval, both enable bits and the pending flag are zero, and `irq_o` is low.
- R2: The interval register is at offset 0x0C. Its fields are seconds in bits [5:0], minutes in bits [13:8], hours in bits [20:16] and days in bits [28:21]. Reading it returns the current remaining interval in the same fields, and all other bits read as zero.
- R3: The interval decreases by one second on each clock where `tick_i` is high, counter-enable bit 8 at offset 0x14 is set, and the interval is nonzero. At no other time does it change, except through a write.
- R4: Borrows follow the time units:
  - seconds at 0 become 59 and take one minute;
  - minutes at 0 become 59 and take one hour;
  - hours at 0 become 23 and take one day.
- R5: A decrement that lands on zero sets the pending flag (bit 0 at offset 0x1C) in the same edge. The interval then holds at zero on later ticks, and the flag is raised only once.
- R6: `irq_o` is high exactly when the pending flag is set and interrupt-enable bit 0 at offset 0x18 is set.
- R7: Writing 1 to status bit 0 clears the pending flag. Writing 0 to it leaves the flag unchanged.
- R8: Writing zero to the interval stops a countdown in progress without setting the pending flag.
- R9: An interval write in the same cycle as a counting tick loads the written value, and the tick is dropped.
- R10: If the pending flag is set and cleared in the same cycle, it ends up set.
- R11: The full day range up to 255 is supported. The interval 255 d 23 h 59 m 59 s decrements to 255 d 23 h 59 m 58 s.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second strobe, one clock wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
- **Result timing:** every write and every counting tick shows its result at the first clock edge after the stimulus: in the interval readback, the status bit and `irq_o`. No result takes more than one cycle.
- **Reference model:** the bench drives inputs after a falling edge. At the rising edge it updates a reference model kept as an integer count of seconds. At the next falling edge it compares `irq_o` and the read data for the current address against the model. Every result is therefore checked in exactly the cycle it becomes due.
- **Same-cycle cases:** the collisions are driven within one cycle: a write together with a tick, and a pending-flag set together with a clear.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DATA_W = 32;
  localparam int DAY_W  = 8;
  localparam int HR_W   = 5;
  localparam int MS_W   = 6;

  localparam logic [7:0] OFF_CNT  = 8'h0C;
  localparam logic [7:0] OFF_RUN  = 8'h14;
  localparam logic [7:0] OFF_IEN  = 8'h18;
  localparam logic [7:0] OFF_STAT = 8'h1C;

  localparam int RUN_BIT = 8;
  localparam int SEC_LSB = 0;
  localparam int MIN_LSB = 8;
  localparam int HR_LSB  = 16;
  localparam int DAY_LSB = 21;

  localparam logic [MS_W-1:0] SEC_TOP = MS_W'(59);
  localparam logic [MS_W-1:0] MIN_TOP = MS_W'(59);
  localparam logic [HR_W-1:0] HR_TOP  = HR_W'(23);

  typedef struct packed {
    logic [DAY_W-1:0] day;
    logic [HR_W-1:0]  hr;
    logic [MS_W-1:0]  min;
    logic [MS_W-1:0]  sec;
  } dhms_t;
endpackage

// File: rtl/alarm_dhms_dec.sv
module alarm_dhms_dec
  import alarm_pkg::*;
(
  input  dhms_t cur_i,
  output dhms_t nxt_o,
  output logic  cur_zero_o,
  output logic  nxt_zero_o
);
  always_comb begin
    nxt_o = cur_i;
    if (cur_i.sec != '0) begin
      nxt_o.sec = cur_i.sec - 1'b1;
    end else begin
      nxt_o.sec = SEC_TOP;
      if (cur_i.min != '0) begin
        nxt_o.min = cur_i.min - 1'b1;
      end else begin
        nxt_o.min = MIN_TOP;
        if (cur_i.hr != '0) begin
          nxt_o.hr = cur_i.hr - 1'b1;
        end else begin
          nxt_o.hr  = HR_TOP;
          nxt_o.day = cur_i.day - 1'b1;
        end
      end
    end
  end

  assign cur_zero_o = (cur_i == '0);
  assign nxt_zero_o = (nxt_o == '0);
endmodule

// File: rtl/alarm_count_core.sv
module alarm_count_core
  import alarm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  dhms_t load_val_i,
  input  logic  step_i,
  output dhms_t cnt_o,
  output logic  term_o
);
  dhms_t cnt_q, cnt_dec;
  logic  cur_zero, nxt_zero, do_dec;

  alarm_dhms_dec u_dec (
    .cur_i      (cnt_q),
    .nxt_o      (cnt_dec),
    .cur_zero_o (cur_zero),
    .nxt_zero_o (nxt_zero)
  );

  assign do_dec = step_i && !load_i && !cur_zero;
  assign term_o = do_dec && nxt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (do_dec) cnt_q <= cnt_dec;
  end

  assign cnt_o = cnt_q;

  p_hold_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  p_idle_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_q));
  p_sec_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_q.sec != '0) |=> (cnt_q.sec == $past(cnt_q.sec) - 1'b1));
  p_term_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> !term_o);
endmodule

// File: rtl/alarm_irq_status.sv
module alarm_irq_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q;

  // set beats a same-cycle clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & ien_i;

  p_pend_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(set_i));
  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_q);
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_q);
endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
  import alarm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic  run_q, ien_q, pend, term;
  logic  sel_cnt, sel_run, sel_ien, sel_stat;
  dhms_t cnt, wr_val;

  assign sel_cnt  = (addr_i == ADDR_W'(OFF_CNT));
  assign sel_run  = (addr_i == ADDR_W'(OFF_RUN));
  assign sel_ien  = (addr_i == ADDR_W'(OFF_IEN));
  assign sel_stat = (addr_i == ADDR_W'(OFF_STAT));

  assign wr_val.sec = wdata_i[SEC_LSB +: MS_W];
  assign wr_val.min = wdata_i[MIN_LSB +: MS_W];
  assign wr_val.hr  = wdata_i[HR_LSB  +: HR_W];
  assign wr_val.day = wdata_i[DAY_LSB +: DAY_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (we_i) begin
      if (sel_run) run_q <= wdata_i[RUN_BIT];
      if (sel_ien) ien_q <= wdata_i[0];
    end
  end

  alarm_count_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (we_i && sel_cnt),
    .load_val_i (wr_val),
    .step_i     (tick_i && run_q),
    .cnt_o      (cnt),
    .term_o     (term)
  );

  alarm_irq_status u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (term),
    .clr_i  (we_i && sel_stat && wdata_i[0]),
    .ien_i  (ien_q),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_cnt) begin
      rdata_o[SEC_LSB +: MS_W]  = cnt.sec;
      rdata_o[MIN_LSB +: MS_W]  = cnt.min;
      rdata_o[HR_LSB  +: HR_W]  = cnt.hr;
      rdata_o[DAY_LSB +: DAY_W] = cnt.day;
    end else if (sel_run) begin
      rdata_o[RUN_BIT] = run_q;
    end else if (sel_ien) begin
      rdata_o[0] = ien_q;
    end else if (sel_stat) begin
      rdata_o[0] = pend;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:DAY_LSB+DAY_W], wdata_i[15:14], wdata_i[7:6]};

  p_irq_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ien_q);
  p_zero_write_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_cnt && wdata_i == '0) |=> (!$rose(pend) && cnt == '0));
endmodule

// File: tb/alarm_countdown_test.sv
module alarm_countdown_test;
  localparam int AW = 5;
  localparam int C = 'h0C, E = 'h14, I = 'h18, S = 'h1C;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = AW'(C);
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int m_total = 0, m_en = 0, m_ie = 0, m_pend = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  alarm_countdown #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  function automatic int enc(int total);
    int d, h, m, s;
    d = total / 86400; h = (total % 86400) / 3600;
    m = (total % 3600) / 60; s = total % 60;
    return (d << 21) | (h << 16) | (m << 8) | s;
  endfunction

  function automatic int dhms(int d, int h, int m, int s);
    return d * 86400 + h * 3600 + m * 60 + s;
  endfunction

  function automatic logic [31:0] m_read(int a);
    case (a)
      C: return 32'(enc(m_total));
      E: return 32'(m_en << 8);
      I: return 32'(m_ie);
      S: return 32'(m_pend);
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare();
    logic [31:0] exp_rd;
    logic exp_irq;
    exp_rd  = m_read(int'(addr));
    exp_irq = (m_pend != 0) && (m_ie != 0);
    n_cmp++;
    if (rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata@%0h actual %h expected %h", tag, addr, rdata, exp_rd);
    end
    n_cmp++;
    if (irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, exp_irq);
    end
  endtask

  task automatic step();
    int set_p;
    @(posedge clk);
    set_p = 0;
    if (we && int'(addr) == C) begin
      m_total = dhms(int'(wdata[28:21]), int'(wdata[20:16]), int'(wdata[13:8]), int'(wdata[5:0]));
    end else if (tick && m_en != 0 && m_total != 0) begin
      m_total--;
      if (m_total == 0) set_p = 1;
    end
    if (set_p != 0) m_pend = 1;
    else if (we && int'(addr) == S && wdata[0]) m_pend = 0;
    if (we && int'(addr) == E) m_en = int'(wdata[8]);
    if (we && int'(addr) == I) m_ie = int'(wdata[0]);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int a, logic [31:0] d, logic t);
    we = 1'b1; addr = AW'(a); wdata = d; tick = t;
    step();
    we = 1'b0; tick = 1'b0; wdata = '0; addr = AW'(C);
  endtask

  task automatic rd(int a);
    addr = AW'(a);
    step();
    addr = AW'(C);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(); tick = 1'b0;
      for (int j = 0; j < gap; j++) step();
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog all-R actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    rd(C); rd(E); rd(I); rd(S);

    tag = "R2";
    wr(C, (32'd0 << 21) | (32'd0 << 16) | (32'd1 << 8) | 32'd5, 1'b0);
    rd(C);
    tag = "R3";
    ticks(3, 1);
    wr(E, 32'h100, 1'b0);
    rd(E);
    ticks(4, 0);
    repeat (3) step();
    tag = "R4";
    ticks(3, 2);

    tag = "R6";
    wr(I, 32'h1, 1'b0);
    tag = "R5";
    ticks(62, 0);
    rd(S);
    ticks(5, 1);
    tag = "R6";
    wr(I, 32'h0, 1'b0);
    wr(I, 32'h1, 1'b0);
    tag = "R7";
    wr(S, 32'h0, 1'b0);
    rd(S);
    wr(S, 32'h1, 1'b0);
    rd(S);

    tag = "R4";
    wr(C, 32'd1 << 21, 1'b0);
    ticks(2, 0);
    wr(C, (32'd0 << 21) | (32'd2 << 16), 1'b0);
    ticks(2, 0);

    tag = "R11";
    wr(C, (32'd255 << 21) | (32'd23 << 16) | (32'd59 << 8) | 32'd59, 1'b0);
    ticks(3, 0);

    tag = "R8";
    wr(C, 32'd40, 1'b0);
    ticks(2, 0);
    wr(C, 32'd0, 1'b1);
    ticks(4, 0);
    rd(S);

    tag = "R9";
    wr(C, 32'd9, 1'b1);
    rd(C);
    ticks(1, 0);

    tag = "R10";
    wr(C, 32'd1, 1'b0);
    wr(S, 32'h1, 1'b1);
    rd(S);
    wr(S, 32'h1, 1'b0);
    wr(C, 32'd1, 1'b0);
    ticks(1, 0);
    wr(S, 32'h1, 1'b1);
    rd(S);

    tag = "R3";
    wr(E, 32'h0, 1'b0);
    wr(C, 32'd3, 1'b0);
    ticks(3, 0);
    rd(C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule